// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal. It counts the rising edges of that signal over a gate time that software selects. A level-sensitive run bit controls it. While the bit is high, the block waits out a settling period first. It then opens the gate and counts the synchronized rising edges of the input until the gate closes. When the gate closes, it freezes the result and raises a done flag. Lowering the run bit returns the block to idle and clears the count.

A millisecond tick input sets the time base for both the settling wait and the gate. The 2-bit gate select is captured when a measurement starts. The four codes give gates of 4, 8, 32 and 64 ms. The two short gates settle for 4 ms and the two long gates settle for 8 ms. A PLL-inhibit input stops the block at once. While inhibit is high, the block stays idle, the count reads zero, and the input is masked to low.

The controller has four states:
- IDLE: the count is cleared.
- SETTLE: the block counts the wait in ticks.
- GATE: edges are counted.
- HOLD: the result is frozen and done is high.

The transitions are:
- start: IDLE to SETTLE, when run is high and inhibit is low.
- open: SETTLE to GATE, on the last tick of the wait.
- close: GATE to HOLD, on the last tick of the gate.
- abort: any other state to IDLE, when run is low or inhibit is high.

Top module: `ifc_gate_counter`

## Requirements
- R1: While reset is asserted and after it is released, count is 0, busy is 0 and done is 0.
- R2: When run_en is high and inhibit is low in idle, busy is 1 one clock later and count stays 0; in idle (busy and done both 0) count is always 0.
- R3: The settling wait lasts WAIT_SHORT ticks (default 4) for gate_sel 2'b00 and 2'b01, and WAIT_LONG ticks (default 8) for 2'b10 and 2'b11. No edge is counted during the wait.
- R4: The gate lasts GATE_T0/1/2/3 ticks (default 4, 8, 32, 64) for gate_sel 2'b00/2'b01/2'b10/2'b11. Busy stays high from start until the last gate tick, so busy lasts between 4(W+G)-3 and 4(W+G) clocks when a tick arrives every 4 clocks.
- R5: During the gate, each low-to-high transition of if_in adds 1 to count, two clocks after the transition (two-flop synchronizer). An edge in the clock of the closing tick is still counted.
- R6: count saturates at 2^CNT_W-1 and never wraps.
- R7: When the gate closes, done goes to 1 and busy to 0. Count then stays frozen, even with if_in toggling, until run_en goes low.
- R8: When run_en is 0 at a clock edge, the block is in idle after that edge, with count, busy and done all 0.
- R9: When inhibit is 1 at a clock edge, the block is in idle after that edge with count 0, and if_in is treated as low. The block stays idle while inhibit is high.
- R10: gate_sel is captured at start. Changing it during a measurement does not change the wait or the gate length.
- R11: busy and done are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-clock pulse marking each millisecond |
| run_en | input | 1 | Level control: 1 runs a measurement, 0 resets the counter |
| gate_sel | input | 2 | Gate/wait code, captured at start |
| inhibit | input | 1 | PLL inhibit: forces idle and masks the input |
| if_in | input | 1 | Asynchronous IF input to be counted |
| count | output | CNT_W | Accumulated edge count, saturating |
| busy | output | 1 | High during settle and gate |
| done | output | 1 | High while the frozen result is held |

## Verification
The bench builds the block with CNT_W = 6. This caps the count at 63, so a 64 ms gate driven by an input that toggles every clock reaches saturation in a few hundred cycles. The tick period is compressed to one tick every 4 clocks, so all four gate codes, the two settling waits and mid-gate aborts by run_en or inhibit fit in a short run. A behavioural reference model, built from queued input samples and integer phase counters, is compared against count, busy and done on every clock.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_GATE   = 2'd2,
        ST_HOLD   = 2'd3
    } ifc_state_e;

endpackage

// File: rtl/ifc_edge_sync.sv
module ifc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic block,
    output logic rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[LAST-1:0], din & ~block};
        end
    end

    assign rise = chain_q[LAST-1] & ~chain_q[LAST];

endmodule

// File: rtl/ifc_sat_counter.sv
module ifc_sat_counter #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (inc && (value != TOP)) begin
            value <= value + W'(1);
        end
    end

endmodule

// File: rtl/ifc_ctrl.sv
module ifc_ctrl
    import ifc_pkg::*;
#(
    parameter int TIME_W     = 8,
    parameter int GATE_T0    = 4,
    parameter int GATE_T1    = 8,
    parameter int GATE_T2    = 32,
    parameter int GATE_T3    = 64,
    parameter int WAIT_SHORT = 4,
    parameter int WAIT_LONG  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       run_en,
    input  logic       inhibit,
    input  logic [1:0] gate_sel,
    output logic       cnt_clr,
    output logic       cnt_en,
    output logic       busy,
    output logic       done
);
    localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

    ifc_state_e        state_q, state_d;
    logic [TIME_W-1:0] tick_q, tick_d;
    logic [1:0]        sel_q, sel_d;
    logic [TIME_W-1:0] gate_len;
    logic [TIME_W-1:0] settle_len;
    logic              abort;

    assign abort = !run_en || inhibit;

    always_comb begin
        unique case (sel_q)
            2'b00:   gate_len = TIME_W'(GATE_T0);
            2'b01:   gate_len = TIME_W'(GATE_T1);
            2'b10:   gate_len = TIME_W'(GATE_T2);
            default: gate_len = TIME_W'(GATE_T3);
        endcase
        settle_len = sel_q[1] ? TIME_W'(WAIT_LONG) : TIME_W'(WAIT_SHORT);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tick_q  <= '0;
            sel_q   <= 2'b00;
        end else begin
            state_q <= state_d;
            tick_q  <= tick_d;
            sel_q   <= sel_d;
        end
    end

    // transitions: start, open, close, abort
    always_comb begin
        state_d = state_q;
        tick_d  = tick_q;
        sel_d   = sel_q;
        unique case (state_q)
            ST_IDLE: begin
                tick_d = '0;
                if (!abort) begin
                    state_d = ST_SETTLE;
                    sel_d   = gate_sel;
                end
            end
            ST_SETTLE: begin
                if (abort) begin
                    state_d = ST_IDLE;
                end else if (ms_tick) begin
                    if (tick_q == settle_len - ONE) begin
                        state_d = ST_GATE;
                        tick_d  = '0;
                    end else begin
                        tick_d = tick_q + ONE;
                    end
                end
            end
            ST_GATE: begin
                if (abort) begin
                    state_d = ST_IDLE;
                end else if (ms_tick) begin
                    if (tick_q == gate_len - ONE) begin
                        state_d = ST_HOLD;
                        tick_d  = '0;
                    end else begin
                        tick_d = tick_q + ONE;
                    end
                end
            end
            ST_HOLD: begin
                if (abort) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = (state_q == ST_SETTLE) || (state_q == ST_GATE);
        done    = (state_q == ST_HOLD);
        cnt_en  = (state_q == ST_GATE) && !abort;
        cnt_clr = (state_q == ST_IDLE) || abort;
    end

endmodule

// File: rtl/ifc_gate_counter.sv
module ifc_gate_counter #(
    parameter int CNT_W      = 20,
    parameter int TIME_W     = 8,
    parameter int SYNC_STG   = 2,
    parameter int GATE_T0    = 4,
    parameter int GATE_T1    = 8,
    parameter int GATE_T2    = 32,
    parameter int GATE_T3    = 64,
    parameter int WAIT_SHORT = 4,
    parameter int WAIT_LONG  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             run_en,
    input  logic [1:0]       gate_sel,
    input  logic             inhibit,
    input  logic             if_in,
    output logic [CNT_W-1:0] count,
    output logic             busy,
    output logic             done
);
    logic rise;
    logic cnt_clr;
    logic cnt_en;

    ifc_edge_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (if_in),
        .block (inhibit),
        .rise  (rise)
    );

    ifc_ctrl #(
        .TIME_W     (TIME_W),
        .GATE_T0    (GATE_T0),
        .GATE_T1    (GATE_T1),
        .GATE_T2    (GATE_T2),
        .GATE_T3    (GATE_T3),
        .WAIT_SHORT (WAIT_SHORT),
        .WAIT_LONG  (WAIT_LONG)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ms_tick  (ms_tick),
        .run_en   (run_en),
        .inhibit  (inhibit),
        .gate_sel (gate_sel),
        .cnt_clr  (cnt_clr),
        .cnt_en   (cnt_en),
        .busy     (busy),
        .done     (done)
    );

    ifc_sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_en && rise),
        .value (count)
    );

endmodule

// File: rtl/ifc_gate_counter_chk.sv
module ifc_gate_counter_chk #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             inhibit,
    input logic [CNT_W-1:0] count,
    input logic             busy,
    input logic             done
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> (count == '0));

    assert_run_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!busy && !done && count == '0));

    assert_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> (!busy && !done && count == '0));

    assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(count));

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == $past(count) + CNT_W'(1) || count == '0));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count) == MAXV) |-> (count == MAXV || count == '0));

endmodule

bind ifc_gate_counter ifc_gate_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .inhibit (inhibit),
    .count   (count),
    .busy    (busy),
    .done    (done)
);

// File: tb/ifc_gate_counter_tb.sv
module ifc_gate_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 6;
    localparam int TICK_DIV   = 4;
    localparam int MAXC       = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ms_tick = 1'b0;
    logic          run_en = 1'b0;
    logic [1:0]    gate_sel = 2'b00;
    logic          inhibit = 1'b0;
    logic          if_in = 1'b0;
    logic [CW-1:0] count;
    logic          busy;
    logic          done;

    int checks = 0;
    int errors = 0;
    int half_p = 0;
    int tog_cnt = 0;
    int tick_cnt = 0;
    int cyc = 0;
    bit finished = 0;

    ifc_gate_counter #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .run_en(run_en),
        .gate_sel(gate_sel), .inhibit(inhibit), .if_in(if_in),
        .count(count), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // stimulus generators: tick every TICK_DIV clocks, optional toggling input
    always @(negedge clk) begin
        tick_cnt = (tick_cnt + 1) % TICK_DIV;
        ms_tick = (tick_cnt == 0);
        if (half_p > 0) begin
            tog_cnt++;
            if (tog_cnt >= half_p) begin
                if_in = ~if_in;
                tog_cnt = 0;
            end
        end
    end

    // behavioural reference model
    int m_phase = 0;
    int m_t = 0;
    int m_sel = 0;
    int m_cnt = 0;
    bit hist[$] = '{0, 0, 0};

    function automatic int gate_ms(input int s);
        case (s)
            0: return 4;
            1: return 8;
            2: return 32;
            default: return 64;
        endcase
    endfunction

    function automatic int wait_ms(input int s);
        return (s >= 2) ? 8 : 4;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_t = 0; m_cnt = 0;
            hist = '{0, 0, 0};
        end else begin
            bit r;
            bit stop;
            r = hist[1] && !hist[0];
            stop = !run_en || inhibit;
            if (stop) begin
                m_phase = 0; m_cnt = 0; m_t = 0;
            end else begin
                case (m_phase)
                    0: begin m_phase = 1; m_sel = int'(gate_sel); m_t = 0; m_cnt = 0; end
                    1: if (ms_tick) begin
                        m_t++;
                        if (m_t == wait_ms(m_sel)) begin m_phase = 2; m_t = 0; end
                    end
                    2: begin
                        if (r && m_cnt < MAXC) m_cnt++;
                        if (ms_tick) begin
                            m_t++;
                            if (m_t == gate_ms(m_sel)) begin m_phase = 3; m_t = 0; end
                        end
                    end
                    default: ;
                endcase
            end
            void'(hist.pop_front());
            hist.push_back(if_in && !inhibit);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(int'(count) == m_cnt, "R5", "model count", int'(count), m_cnt);
            chk(busy == (m_phase == 1 || m_phase == 2), "R4", "model busy", busy, (m_phase == 1 || m_phase == 2));
            chk(done == (m_phase == 3), "R7", "model done", done, (m_phase == 3));
            chk(!(busy && done), "R11", "busy&done", int'(busy && done), 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    // run one measurement; returns clocks with busy high
    task automatic measure(input logic [1:0] sel, input int zero_win,
                           input int swap_at, output int busy_cyc);
        gate_sel = sel;
        run_en = 1'b1;
        busy_cyc = 0;
        @(negedge clk);
        while (!done && busy_cyc < 2000) begin
            if (busy) busy_cyc++;
            if (busy_cyc == swap_at) gate_sel = ~sel;
            if (busy_cyc <= zero_win)
                chk(count == '0, "R3", "count during wait", int'(count), 0);
            @(negedge clk);
        end
    endtask

    task automatic stop_run();
        run_en = 1'b0;
        @(negedge clk);
        chk(count == '0 && !busy && !done, "R8", "idle after run low",
            int'(count), 0);
    endtask

    int bc;
    int lo;
    int hi;

    initial begin
        repeat (3) @(negedge clk);
        chk(count == '0 && !busy && !done, "R1", "in reset", int'(count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(count == '0 && !busy && !done, "R1", "after reset", int'(count), 0);

        // R2: busy one clock after start
        half_p = 1;
        gate_sel = 2'b00;
        run_en = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1 && count == '0, "R2", "busy after start", busy, 1);
        run_en = 1'b0;
        @(negedge clk);

        // R3/R4 code 00
        measure(2'b00, 4 * 4 - 3, -1, bc);
        chk(bc >= 29 && bc <= 32, "R4", "busy length code00", bc, 32);
        // R7: frozen while input toggles
        lo = int'(count);
        repeat (12) @(negedge clk);
        chk(done && int'(count) == lo, "R7", "frozen result", int'(count), lo);
        stop_run();

        // R5 code 01 with slow input
        half_p = 4;
        measure(2'b01, 4 * 4 - 3, -1, bc);
        chk(bc >= 45 && bc <= 48, "R4", "busy length code01", bc, 48);
        chk(count >= 3 && count <= 5, "R5", "edges in 32 clocks", int'(count), 4);
        stop_run();

        // code 10, long wait
        half_p = 2;
        measure(2'b10, 4 * 8 - 3, -1, bc);
        chk(bc >= 157 && bc <= 160, "R4", "busy length code10", bc, 160);
        chk(busy_zero_ok(bc), "R3", "long wait ran", bc, 160);
        stop_run();

        // R6 saturation on code 11
        half_p = 1;
        measure(2'b11, 4 * 8 - 3, -1, bc);
        chk(bc >= 285 && bc <= 288, "R4", "busy length code11", bc, 288);
        chk(int'(count) == MAXC, "R6", "saturated count", int'(count), MAXC);
        repeat (6) @(negedge clk);
        chk(int'(count) == MAXC, "R6", "no wrap", int'(count), MAXC);
        stop_run();

        // R10: gate_sel changed mid-measurement
        measure(2'b00, 0, 3, bc);
        chk(bc >= 29 && bc <= 32, "R10", "captured select", bc, 32);
        stop_run();

        // R8: abort during gate
        gate_sel = 2'b01;
        run_en = 1'b1;
        repeat (30) @(negedge clk);
        chk(busy == 1'b1, "R8", "busy before abort", busy, 1);
        stop_run();

        // R9: inhibit during gate with input held high
        run_en = 1'b1;
        repeat (30) @(negedge clk);
        half_p = 0;
        if_in = 1'b1;
        inhibit = 1'b1;
        @(negedge clk);
        chk(count == '0 && !busy && !done, "R9", "inhibit clears", int'(count), 0);
        repeat (8) @(negedge clk);
        chk(!busy && !done, "R9", "held idle", busy, 0);
        inhibit = 1'b0;
        hi = 0;
        @(negedge clk);
        while (!done && hi < 400) begin hi++; @(negedge clk); end
        chk(done == 1'b1, "R9", "restart after release", done, 1);
        stop_run();

        repeat (4) @(negedge clk);
        finish_run();
    end

    function automatic bit busy_zero_ok(input int b);
        return b > 4 * 8;
    endfunction

endmodule